// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides, at each instruction boundary, whether the core should leave its program flow to service an interrupt. Eleven peripheral sources raise single-cycle request pulses. Each pulse is captured in a pending flag that stays set until the source is serviced or software clears it. At a boundary, the controller chooses one pending source. That source must have its own enable bit set, and the global enable bit must also be set. The controller raises a one-cycle take request with the vector number, and acknowledges exactly that source.

The global enable bit is owned here. It resets to 0. Entering any vector clears it in hardware. A return-from-interrupt strobe sets it again, and two further strobes from the core set or clear it directly. The core expects its stack pointer to change by two for each return address, so every entry and return is also reported as a signed stack adjustment.

Vector 0 is the reset vector and has the highest priority. The first instruction boundary after reset always delivers vector 0, whatever the global enable bit holds, and any pending peripheral requests stay pending. Peripheral source `k` (bit `k` of every per-source bus) maps to vector `k+1`. Lower vector numbers win.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source index k (bit k of `reqPulse`, `srcEnable`, `clrPending`, `ackOneHot`) is delivered as vector k+1. The order is: 1 external line, 2 pin change, 3 timer1 compare A, 4 timer1 compare B, 5 timer1 overflow, 6 timer0 overflow, 7 serial start, 8 serial overflow, 9 EEPROM ready, 10 comparator, 11 ADC complete. Vector 0 is reset.
- R2: When several sources are eligible at once, the lowest vector number is taken, and reset (vector 0) comes before all others.
- R3: A peripheral source is taken only when its pending flag, its `srcEnable` bit and the global enable are all 1 at the boundary.
- R4: Every accepted vector clears the global enable bit on the same clock edge at which it is accepted.
- R5: `retStrobe` or `setGieStrobe` sets the global enable bit, and `clrGieStrobe` clears it. If several act on the same edge, acceptance wins over clear, and clear wins over set or return.
- R6: `stackDelta` is a 4-bit two's complement value, valid in the cycle after the edge. It is -2 (4'b1110) when a peripheral vector is taken, +2 (4'b0010) after a return that coincides with no acceptance, and 0 otherwise, including on reset-vector entry.
- R7: After reset the global enable is 0, and `takeIrq`, `vectorNum`, `ackOneHot` and `stackDelta` are all 0.
- R8: A request pulse sets its pending flag. The flag holds until the source is acknowledged or its `clrPending` bit is 1. A pulse on the same edge as a clear or an acknowledge leaves the flag set.
- R9: Arbitration happens only on an edge where `instrBoundary` is 1. The take lasts one cycle, in the cycle after that edge, and acknowledges exactly one source. When `takeIrq` is 0, `vectorNum` and `ackOneHot` are 0.
- R10: The first boundary after reset takes vector 0 with no source acknowledged, regardless of the global enable, and only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPulse | input | 11 | Per-source request pulses |
| srcEnable | input | 11 | Per-source enable bits |
| clrPending | input | 11 | Per-source software clear of the pending flag |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| retStrobe | input | 1 | Return-from-interrupt executed |
| setGieStrobe | input | 1 | Software sets global enable |
| clrGieStrobe | input | 1 | Software clears global enable |
| takeIrq | output | 1 | One-cycle take-interrupt request |
| vectorNum | output | 4 | Vector number of the taken interrupt |
| ackOneHot | output | 11 | One-hot acknowledge of the serviced source |
| gieState | output | 1 | Global interrupt enable bit (status bit 7) |
| stackDelta | output | 4 | Signed stack pointer adjustment |

## Verification
A pending flag that was lost or stuck shows up at the next enabled boundary. It appears as a missing take, or as a vector that should have lost to a lower-numbered one. The acknowledge then points at the wrong source in that same cycle.

A wrong global enable bit shows up one cycle after the offending edge, either directly on `gieState` or as an extra or missing take at the following boundary. A wrong stack adjustment shows up in the cycle after the take or return.

The reset-vector flag is exposed at the first boundary after reset.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic accept;       // a vector is accepted on this edge
    logic acceptReset;  // the accepted vector is the reset vector
  } irqStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] clrPending,
  input  irqStrobe_t         strobes,
  output logic               anyMasked,
  output logic               takeIrq,
  output logic [VEC_W-1:0]   vectorNum,
  output logic [NUM_SRC-1:0] ackOneHot
);
  logic [NUM_SRC-1:0] pendFlag;
  logic [NUM_SRC-1:0] maskedReq;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC:0]   seenLower;
  logic [NUM_SRC-1:0] ackNow;
  logic [VEC_W-1:0]   winVec;

  assign maskedReq    = pendFlag & srcEnable;
  assign anyMasked    = |maskedReq;
  assign seenLower[0] = 1'b0;

  // Fixed priority chain: lower index (lower vector) wins
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
    assign grant[g]       = maskedReq[g] & ~seenLower[g];
    assign seenLower[g+1] = seenLower[g] | maskedReq[g];
  end

  always_comb begin
    winVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) winVec = winVec | VEC_W'(i + 1);
    end
  end

  assign ackNow = (strobes.accept && !strobes.acceptReset) ? grant : '0;

  // Pending flags: a new pulse wins over acknowledge and clear
  for (genvar p = 0; p < NUM_SRC; p++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN)              pendFlag[p] <= 1'b0;
      else if (reqPulse[p])   pendFlag[p] <= 1'b1;
      else if (ackNow[p] || clrPending[p]) pendFlag[p] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq   <= 1'b0;
      vectorNum <= '0;
      ackOneHot <= '0;
    end else begin
      takeIrq   <= strobes.accept;
      vectorNum <= (strobes.accept && !strobes.acceptReset) ? winVec : '0;
      ackOneHot <= ackNow;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int STACK_STEP = 2,
  parameter int DELTA_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrBoundary,
  input  logic               anyMasked,
  input  logic               retStrobe,
  input  logic               setGieStrobe,
  input  logic               clrGieStrobe,
  output irqStrobe_t         strobes,
  output logic               gieState,
  output logic [DELTA_W-1:0] stackDelta
);
  localparam logic [DELTA_W-1:0] PushDelta = DELTA_W'(-STACK_STEP);
  localparam logic [DELTA_W-1:0] PopDelta  = DELTA_W'(STACK_STEP);

  logic resetVecDue;
  logic acceptNow;

  assign acceptNow           = instrBoundary & (resetVecDue | (gieState & anyMasked));
  assign strobes.accept      = acceptNow;
  assign strobes.acceptReset = instrBoundary & resetVecDue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetVecDue <= 1'b1;
      gieState    <= 1'b0;
      stackDelta  <= '0;
    end else begin
      if (strobes.acceptReset) resetVecDue <= 1'b0;

      if (acceptNow)                       gieState <= 1'b0;
      else if (clrGieStrobe)               gieState <= 1'b0;
      else if (retStrobe || setGieStrobe)  gieState <= 1'b1;

      if (acceptNow)      stackDelta <= strobes.acceptReset ? '0 : PushDelta;
      else if (retStrobe) stackDelta <= PopDelta;
      else                stackDelta <= '0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC    = 11,
  parameter int VEC_W      = $clog2(NUM_SRC + 1),
  parameter int STACK_STEP = 2,
  parameter int DELTA_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] clrPending,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  input  logic               setGieStrobe,
  input  logic               clrGieStrobe,
  output logic               takeIrq,
  output logic [VEC_W-1:0]   vectorNum,
  output logic [NUM_SRC-1:0] ackOneHot,
  output logic               gieState,
  output logic [DELTA_W-1:0] stackDelta
);
  irqStrobe_t strobes;
  logic       anyMasked;

  irq_control #(.STACK_STEP(STACK_STEP), .DELTA_W(DELTA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .anyMasked(anyMasked),
    .retStrobe(retStrobe), .setGieStrobe(setGieStrobe), .clrGieStrobe(clrGieStrobe),
    .strobes(strobes), .gieState(gieState), .stackDelta(stackDelta)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) uData (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .srcEnable(srcEnable),
    .clrPending(clrPending), .strobes(strobes), .anyMasked(anyMasked),
    .takeIrq(takeIrq), .vectorNum(vectorNum), .ackOneHot(ackOneHot)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC    = 11,
  parameter int VEC_W      = 4,
  parameter int STACK_STEP = 2,
  parameter int DELTA_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrBoundary,
  input logic               retStrobe,
  input logic               setGieStrobe,
  input logic               clrGieStrobe,
  input logic               takeIrq,
  input logic [VEC_W-1:0]   vectorNum,
  input logic [NUM_SRC-1:0] ackOneHot,
  input logic               gieState,
  input logic [DELTA_W-1:0] stackDelta
);
  localparam logic [DELTA_W-1:0] PushDelta = DELTA_W'(-STACK_STEP);

  // R1: acknowledge bit matches the vector number
  assert_ack_matches_vector_R1: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vectorNum != '0) |-> (ackOneHot == (NUM_SRC'(1) << (vectorNum - 1'b1))));

  // R3: a peripheral vector needs the global enable before the edge
  assert_take_needs_gie_R3: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vectorNum != '0) |-> $past(gieState));

  // R4: enable is low while a take is presented
  assert_gie_cleared_on_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !gieState);

  // R5: the enable rises only through a set or return strobe
  assert_gie_rise_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gieState) |-> $past(retStrobe || setGieStrobe));

  // R5: the enable falls only through acceptance or a clear strobe
  assert_gie_fall_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gieState) |-> (takeIrq || $past(clrGieStrobe)));

  // R6: entry adjusts the stack by the push amount, reset entry by nothing
  assert_stack_on_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (stackDelta == ((vectorNum == '0) ? '0 : PushDelta)));

  // R9: takes follow a boundary, are single-cycle, and ack is one-hot
  assert_take_at_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrBoundary));
  assert_take_single_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq);
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOneHot) && (!takeIrq -> (ackOneHot == '0 && vectorNum == '0)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .STACK_STEP(STACK_STEP), .DELTA_W(DELTA_W)
) uChk (
  .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .retStrobe(retStrobe),
  .setGieStrobe(setGieStrobe), .clrGieStrobe(clrGieStrobe), .takeIrq(takeIrq),
  .vectorNum(vectorNum), .ackOneHot(ackOneHot), .gieState(gieState),
  .stackDelta(stackDelta)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  localparam int N = 11;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] reqPulse, srcEnable, clrPending;
  logic         instrBoundary, retStrobe, setGieStrobe, clrGieStrobe;
  logic         takeIrq, gieState;
  logic [3:0]   vectorNum, stackDelta;
  logic [N-1:0] ackOneHot;

  int vecCount = 0;
  int errCount = 0;

  // Bench model state, derived from the requirements
  logic [N-1:0] mPend;
  logic         mGie, mRstDue;

  always #4 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .srcEnable(srcEnable),
    .clrPending(clrPending), .instrBoundary(instrBoundary), .retStrobe(retStrobe),
    .setGieStrobe(setGieStrobe), .clrGieStrobe(clrGieStrobe), .takeIrq(takeIrq),
    .vectorNum(vectorNum), .ackOneHot(ackOneHot), .gieState(gieState),
    .stackDelta(stackDelta)
  );

  // Lowest set bit index, or -1
  function automatic int lowestSet(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] en,
                      input logic [N-1:0] cp, input logic bnd, input logic rt,
                      input logic sg, input logic cg, input string tag);
    logic [N-1:0] mask, eAck;
    logic eTake, eGie;
    logic [3:0] eVec, eDelta;
    int w;
    reqPulse = rq; srcEnable = en; clrPending = cp;
    instrBoundary = bnd; retStrobe = rt; setGieStrobe = sg; clrGieStrobe = cg;
    mask  = mPend & en;
    eTake = bnd && (mRstDue || (mGie && (mask != '0)));
    eVec = 4'd0; eAck = '0;
    if (eTake && !mRstDue) begin
      w = lowestSet(mask);
      eVec = 4'(w + 1);
      eAck = N'(1) << w;
    end
    eDelta = eTake ? (mRstDue ? 4'd0 : 4'b1110) : (rt ? 4'b0010 : 4'd0);
    eGie = eTake ? 1'b0 : cg ? 1'b0 : (sg || rt) ? 1'b1 : mGie;
    @(posedge clk);
    @(negedge clk);
    vecCount++;
    if (takeIrq !== eTake || vectorNum !== eVec || ackOneHot !== eAck ||
        gieState !== eGie || stackDelta !== eDelta) begin
      errCount++;
      $display("FAIL %s: take=%0b vec=%0d ack=%h gie=%0b dlt=%h expected take=%0b vec=%0d ack=%h gie=%0b dlt=%h",
               tag, takeIrq, vectorNum, ackOneHot, gieState, stackDelta,
               eTake, eVec, eAck, eGie, eDelta);
    end
    for (int i = 0; i < N; i++) begin
      if (rq[i]) mPend[i] = 1'b1;
      else if (eAck[i] || cp[i]) mPend[i] = 1'b0;
    end
    if (eTake && mRstDue) mRstDue = 1'b0;
    mGie = eGie;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog R9: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    logic [N-1:0] allEn;
    void'($urandom(32'h5EED_1A7C));
    allEn = '1;
    rstN = 1'b0;
    reqPulse = '0; srcEnable = '0; clrPending = '0;
    instrBoundary = 1'b0; retStrobe = 1'b0; setGieStrobe = 1'b0; clrGieStrobe = 1'b0;
    mPend = '0; mGie = 1'b0; mRstDue = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state
    vecCount++;
    if (takeIrq !== 1'b0 || vectorNum !== 4'd0 || ackOneHot !== '0 ||
        gieState !== 1'b0 || stackDelta !== 4'd0) begin
      errCount++;
      $display("FAIL R7 reset: take=%0b vec=%0d ack=%h gie=%0b dlt=%h expected all zero",
               takeIrq, vectorNum, ackOneHot, gieState, stackDelta);
    end
    rstN = 1'b1;

    // R10: first boundary takes the reset vector even with a pending source
    step(N'(1) << 3, allEn, '0, 1'b0, 0, 0, 0, "R8 latch");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R10 reset vector");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R3 gie off blocks");
    // R5: set enable, then R1/R4/R6 entry of source 3 -> vector 4
    step('0, allEn, '0, 1'b0, 0, 1, 0, "R5 set");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R1 R4 R6 entry");
    // R2: sources 5 and 2 pending, vector 3 wins
    step((N'(1) << 5) | (N'(1) << 2), allEn, '0, 1'b0, 1, 0, 0, "R5 R6 return");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R2 priority");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R3 no gie after entry");
    step('0, allEn, '0, 1'b0, 1, 0, 0, "R6 return");
    // R9: no boundary, no take
    step('0, allEn, '0, 1'b0, 0, 0, 0, "R9 no boundary");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R1 vector 6");
    // R3: source disabled by its enable bit
    step('0, allEn, '0, 1'b0, 0, 1, 0, "R5 set");
    step(N'(1) << 10, '0, '0, 1'b0, 0, 0, 0, "R8 latch");
    step('0, ~(N'(1) << 10), '0, 1'b1, 0, 0, 0, "R3 enable low");
    // R8: software clear, then same-edge request and clear
    step('0, allEn, N'(1) << 10, 1'b0, 0, 0, 0, "R8 clear");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R8 cleared no take");
    step(N'(1), allEn, N'(1), 1'b0, 0, 0, 0, "R8 pulse beats clear");
    step('0, allEn, '0, 1'b1, 0, 0, 0, "R8 R1 vector 1");
    // R5: clear beats set, then set alone
    step('0, allEn, '0, 1'b0, 0, 1, 1, "R5 clear wins");
    step('0, allEn, '0, 1'b0, 0, 1, 0, "R5 set");
    step('0, allEn, '0, 1'b0, 0, 0, 1, "R5 clear");

    // Constrained random mix
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq, cp, en;
      rq = '0; cp = '0;
      for (int b = 0; b < N; b++) begin
        if ($urandom_range(0, 9) == 0) rq[b] = 1'b1;
        if ($urandom_range(0, 29) == 0) cp[b] = 1'b1;
      end
      en = N'($urandom) | N'($urandom);
      step(rq, en, cp, 1'($urandom_range(0, 1)), $urandom_range(0, 11) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
           "R1 R2 R3 R4 R5 R6 R8 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule